// File: doc/BRIEF.md
# Triple-Channel Pixel Output Formatter

This block sits behind a three-channel video digitizer. On every edge of the sampling clock it takes one red, one green and one blue sample, each 8 bits wide, and puts them on the output ports in one of two formats. In single-port format every pixel leaves on port A, one pixel per sampling clock. In dual-port format the pixels of a line are split in pairs. The even pixel goes to port A and the odd pixel that follows it goes to port B, so each port runs at half the sampling rate. The two ports either change together (parallel) or port B trails port A by one sampling clock (interleaved).

The block also drives an output data clock and its complement, so that downstream logic can strobe the ports. It re-times the horizontal sync so that its active-high output rises together with the first pixel of its line. Pixel numbering and the choice of format are both re-anchored at every horizontal sync leading edge, so a line is never split across two formats. The format inputs are static configuration. A power-down input removes the output enables of all data ports and of the sync output. The pad ring turns these enables into tri-states.

Top module: `pixel_port_formatter`

## Requirements
- R1: Each channel is 8-bit straight binary and passes through unaltered: 0x00 (lowest level) and 0xFF (highest level) reach the port bit-exact, with red in the top byte of the internal bus.
- R2: In single-port format, a pixel captured at sampling edge e appears on port A after edge e+5, and port A takes a new pixel on every edge.
- R3: In dual-port format each port holds each value for two sampling clocks. The pixel captured on the edge where the normalised sync is first seen active is index 0 (even), and the following pixels alternate odd and even.
- R4: In parallel dual-port format, an even pixel captured at edge e and the odd pixel captured at e+1 appear together, on port A and port B respectively, after edge e+6.
- R5: In interleaved dual-port format, the even pixel captured at edge e appears on port A after edge e+6, and its odd partner appears on port B after edge e+7.
- R6: The port B output enable is low for lines in single-port format and high for lines in dual-port format.
- R7: While power-down is high, the enables of port A, port B and the sync output are all low in the same cycle. The pipeline keeps running, so data is correct again as soon as power-down falls.
- R8: In single-port format the data clock is the inverse of the sampling clock. In dual-port format it is low for the sampling clock after port A updates and high for the next one. The complementary clock output is always the inverse of the data clock.
- R9: The sync output is the normalised sync input delayed by 5 sampling clocks in single-port format and 6 in dual-port format, so its rising edge appears together with pixel index 0 on port A.
- R10: When the sync polarity input is 1, the sync input is treated as active-low. The sync output is active-high in either case.
- R11: A change of the format inputs takes effect only at the next sync leading edge. A change in mid-line leaves the current line in its format.
- R12: After reset, port A data is 0, its enable is high, the port B enable is low, the sync output is low and single-port format is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_r | input | 8 | Red sample |
| pix_g | input | 8 | Green sample |
| pix_b | input | 8 | Blue sample |
| hs_in | input | 1 | Horizontal sync, polarity set by hs_active_low |
| hs_active_low | input | 1 | 1 means hs_in is active-low |
| cfg_dual | input | 1 | 1 selects dual-port format |
| cfg_interleave | input | 1 | In dual-port format, 1 selects interleaved timing |
| pwr_down | input | 1 | Drops all data and sync output enables |
| porta_r | output | 8 | Port A red |
| porta_g | output | 8 | Port A green |
| porta_b | output | 8 | Port A blue |
| portb_r | output | 8 | Port B red |
| portb_g | output | 8 | Port B green |
| portb_b | output | 8 | Port B blue |
| porta_oe | output | 1 | Port A output enable |
| portb_oe | output | 1 | Port B output enable |
| hs_out | output | 1 | Re-timed active-high sync |
| hs_oe | output | 1 | Sync output enable |
| dclk | output | 1 | Output data clock |
| dclk_n | output | 1 | Inverse of dclk |

## Verification
The bench notes the edge number that captures each driven pixel and sync level. From that number it works out when each result is due: port A 5 edges later in single-port format, or 6 edges after the even pixel in dual-port format. Port B is due 6 edges after the even pixel in parallel timing and 7 in interleaved timing. The sync output is due at the same 5 or 6 edges, and the data-clock phase counts from the first port A update of the line. Every sample is taken 1.5 ns after a rising edge, so the value read is the one that edge produced. Within a line, checks run only between the first settled pair and the last pixel of the line. The sync leading edge is checked on its exact due cycle.

// File: rtl/pixfmt_pkg.sv
`timescale 1ns/1ps
package pixfmt_pkg;
  localparam int PIX_W = 8;
  localparam int NCH   = 3;
  localparam int BUS_W = PIX_W * NCH;

  // one pixel slot travelling down the pipeline
  typedef struct packed {
    logic [BUS_W-1:0] pix;   // {red, green, blue}
    logic             hs;    // normalised (active-high) sync
    logic             odd;   // pixel index parity within the line
    logic             dual;  // format latched for this line
    logic             intl;  // interleaved timing latched for this line
  } slot_t;

  function automatic logic sync_norm(input logic raw, input logic act_low);
    return raw ^ act_low;
  endfunction

  function automatic logic lead_edge(input logic prev, input logic cur);
    return cur & ~prev;
  endfunction

  function automatic logic next_parity(input logic lead, input logic prev_odd);
    return lead ? 1'b0 : ~prev_odd;
  endfunction
endpackage

// File: rtl/pixfmt_capture.sv
`timescale 1ns/1ps
module pixfmt_capture
  import pixfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] pix_in,
  input  logic             hs_raw,
  input  logic             hs_act_low,
  input  logic             cfg_dual,
  input  logic             cfg_intl,
  output slot_t            cap_q
);
  logic hs_n, hs_prev, lead_evt;
  logic act_dual, act_intl;

  assign hs_n     = sync_norm(hs_raw, hs_act_low);
  assign lead_evt = lead_edge(hs_prev, hs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_prev  <= 1'b0;
      act_dual <= 1'b0;
      act_intl <= 1'b0;
      cap_q    <= '0;
    end else begin
      hs_prev    <= hs_n;
      if (lead_evt) begin
        act_dual <= cfg_dual;
        act_intl <= cfg_intl;
      end
      cap_q.pix  <= pix_in;
      cap_q.hs   <= hs_n;
      cap_q.odd  <= next_parity(lead_evt, cap_q.odd);
      cap_q.dual <= lead_evt ? cfg_dual : act_dual;
      cap_q.intl <= lead_evt ? cfg_intl : act_intl;
    end
  end

  // format latch moves only on a sync leading edge
  assert_mode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_evt |=> ($stable(act_dual) && $stable(act_intl)));

  // parity alternates between leading edges
  assert_parity_alt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lead_evt |=> (cap_q.odd != $past(cap_q.odd)));
endmodule

// File: rtl/pixfmt_delay.sv
`timescale 1ns/1ps
module pixfmt_delay
  import pixfmt_pkg::*;
#(
  parameter int TAP_LO = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  slot_t d_in,
  output slot_t tap_lo,
  output slot_t tap_hi
);
  localparam int DEPTH = TAP_LO + 1;

  slot_t [DEPTH:1] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[1] <= d_in;
      for (int k = 2; k <= DEPTH; k++) st[k] <= st[k-1];
    end
  end

  if (TAP_LO == 0) begin : g_tap_direct
    assign tap_lo = d_in;
  end else begin : g_tap_stage
    assign tap_lo = st[TAP_LO];
  end
  assign tap_hi = st[DEPTH];
endmodule

// File: rtl/pixfmt_port_mux.sv
`timescale 1ns/1ps
module pixfmt_port_mux
  import pixfmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  slot_t            lo,      // newer tap
  input  slot_t            hi,      // one sampling clock older
  output logic [BUS_W-1:0] porta_d,
  output logic [BUS_W-1:0] portb_d,
  output logic             out_dual,
  output logic             dhalf,
  output logic             hs_q
);
  // named load events
  logic single_ld, par_ld, il_a, il_b;
  logic a_load, b_load, dual_a_ld;
  logic [BUS_W-1:0] a_src, b_src;

  always_comb begin
    single_ld = ~lo.dual;
    par_ld    = lo.dual & ~lo.intl & lo.odd;
    il_a      = hi.dual & hi.intl & ~hi.odd;
    il_b      = hi.dual & hi.intl & hi.odd;
    a_load    = single_ld | par_ld | il_a;
    b_load    = par_ld | il_b;
    dual_a_ld = par_ld | il_a;
    // the newer line wins where two rules meet at a boundary
    if (single_ld)   a_src = lo.pix;
    else             a_src = hi.pix;
    if (par_ld)      b_src = lo.pix;
    else             b_src = hi.pix;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      porta_d  <= '0;
      portb_d  <= '0;
      out_dual <= 1'b0;
      dhalf    <= 1'b0;
      hs_q     <= 1'b0;
    end else begin
      if (a_load) porta_d <= a_src;
      if (b_load) portb_d <= b_src;
      out_dual <= lo.dual;
      dhalf    <= ~dual_a_ld;
      hs_q     <= lo.dual ? hi.hs : lo.hs;
    end
  end

  assert_single_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lo.dual |=> (porta_d == $past(lo.pix)));

  assert_par_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    par_ld |=> ((porta_d == $past(hi.pix)) && (portb_d == $past(lo.pix))));

  assert_intl_b_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    il_b |-> $past(il_a));
endmodule

// File: rtl/pixel_port_formatter.sv
`timescale 1ns/1ps
module pixel_port_formatter
  import pixfmt_pkg::*;
#(
  parameter int LAT_SINGLE = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PIX_W-1:0] pix_r,
  input  logic [PIX_W-1:0] pix_g,
  input  logic [PIX_W-1:0] pix_b,
  input  logic             hs_in,
  input  logic             hs_active_low,
  input  logic             cfg_dual,
  input  logic             cfg_interleave,
  input  logic             pwr_down,
  output logic [PIX_W-1:0] porta_r,
  output logic [PIX_W-1:0] porta_g,
  output logic [PIX_W-1:0] porta_b,
  output logic [PIX_W-1:0] portb_r,
  output logic [PIX_W-1:0] portb_g,
  output logic [PIX_W-1:0] portb_b,
  output logic             porta_oe,
  output logic             portb_oe,
  output logic             hs_out,
  output logic             hs_oe,
  output logic             dclk,
  output logic             dclk_n
);
  // capture register is one stage; the output register is another
  localparam int TAP_LO = LAT_SINGLE - 1;

  slot_t            cap_q, tap_lo, tap_hi;
  logic [BUS_W-1:0] porta_d, portb_d;
  logic             out_dual, dhalf, hs_q;

  pixfmt_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_in     ({pix_r, pix_g, pix_b}),
    .hs_raw     (hs_in),
    .hs_act_low (hs_active_low),
    .cfg_dual   (cfg_dual),
    .cfg_intl   (cfg_interleave),
    .cap_q      (cap_q)
  );

  pixfmt_delay #(.TAP_LO(TAP_LO)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_in   (cap_q),
    .tap_lo (tap_lo),
    .tap_hi (tap_hi)
  );

  pixfmt_port_mux u_mux (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo       (tap_lo),
    .hi       (tap_hi),
    .porta_d  (porta_d),
    .portb_d  (portb_d),
    .out_dual (out_dual),
    .dhalf    (dhalf),
    .hs_q     (hs_q)
  );

  assign {porta_r, porta_g, porta_b} = porta_d;
  assign {portb_r, portb_g, portb_b} = portb_d;
  assign porta_oe = ~pwr_down;
  assign portb_oe = out_dual & ~pwr_down;
  assign hs_oe    = ~pwr_down;
  assign hs_out   = hs_q;
  assign dclk     = out_dual ? dhalf : ~clk;
  assign dclk_n   = ~dclk;

  assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (!porta_oe && !portb_oe && !hs_oe));
endmodule

// File: tb/tb_pixel_port_formatter.sv
`timescale 1ns/1ps
module tb_pixel_port_formatter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] pix_r, pix_g, pix_b;
  logic       hs_in, hs_active_low, cfg_dual, cfg_interleave, pwr_down;
  logic [7:0] porta_r, porta_g, porta_b, portb_r, portb_g, portb_b;
  logic       porta_oe, portb_oe, hs_out, hs_oe, dclk, dclk_n;

  always #2.5 clk = ~clk;

  pixel_port_formatter dut (
    .clk(clk), .rst_n(rst_n), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
    .hs_in(hs_in), .hs_active_low(hs_active_low), .cfg_dual(cfg_dual),
    .cfg_interleave(cfg_interleave), .pwr_down(pwr_down),
    .porta_r(porta_r), .porta_g(porta_g), .porta_b(porta_b),
    .portb_r(portb_r), .portb_g(portb_g), .portb_b(portb_b),
    .porta_oe(porta_oe), .portb_oe(portb_oe), .hs_out(hs_out), .hs_oe(hs_oe),
    .dclk(dclk), .dclk_n(dclk_n)
  );

  int ecnt = 0;
  always @(posedge clk) ecnt <= ecnt + 1;

  logic [23:0] hist_pix [0:4095];
  logic        hist_hs  [0:4095];
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at edge %0d: actual %h expected %h", tag, ecnt, act, exp);
    end
  endtask

  function automatic logic [23:0] pgen(input int seed, input int k);
    if (k == 2) return 24'hFFFFFF;
    if (k == 3) return 24'h000000;
    return {8'(k*37 + seed), 8'(k*11 + seed*3), 8'(255 - k*5 - seed)};
  endfunction

  task automatic step();
    @(posedge clk);
    #1.5;
  endtask

  task automatic drive(input logic [23:0] p, input logic hsn);
    {pix_r, pix_g, pix_b} = p;
    hs_in = hsn ^ hs_active_low;
    hist_pix[ecnt+1] = p;
    hist_hs[ecnt+1]  = hsn;
  endtask

  // one line plus idle tail, checked every cycle
  task automatic run_line(input bit dual, input bit intl, input bit alow, input int len,
                          input int hw, input int seed, input int flip_at, input int pd_at);
    int L;
    L = 0;
    for (int k = 0; k < len + 8; k++) begin
      int n;
      step();
      n = ecnt;
      if (k == 0) L = n + 1;
      if (k > 0) begin
        int lat;
        string hs_tag, dtag;
        logic [23:0] a, b, e;
        lat    = dual ? 6 : 5;
        hs_tag = alow ? "R10" : "R9";
        dtag   = (flip_at >= 0 && n > L + flip_at) ? "R11" : "";
        a = {porta_r, porta_g, porta_b};
        b = {portb_r, portb_g, portb_b};
        if (!pwr_down && (n == L + lat - 1 || n == L + lat))
          chk(hs_out == hist_hs[n-lat], hs_tag, 24'(hs_out), 24'(hist_hs[n-lat]));
        if (n >= L + 7 && n <= L + len + 3) begin
          if (pwr_down) begin
            chk(!porta_oe && !portb_oe && !hs_oe, "R7", {porta_oe, portb_oe, hs_oe}, 24'd0);
          end else begin
            chk(porta_oe && hs_oe, "R7", {porta_oe, hs_oe}, 24'd3);
            chk(hs_out == hist_hs[n-lat], hs_tag, 24'(hs_out), 24'(hist_hs[n-lat]));
            chk(portb_oe == dual, "R6", 24'(portb_oe), 24'(dual));
            chk(dclk_n == ~dclk, "R8", {dclk, dclk_n}, {~dclk_n, dclk_n});
            if (!dual) begin
              e = hist_pix[n-5];
              if (dtag == "") dtag = (e == 24'h0 || e == 24'hFFFFFF) ? "R1" : "R2";
              chk(a == e, dtag, a, e);
              chk(dclk == 1'b0, "R8", 24'(dclk), 24'd0);
            end else begin
              int ja, jb;
              ja = (n - L - 6) / 2;
              chk(dclk == ((n - L - 6) % 2 != 0), "R8", 24'(dclk), 24'((n - L - 6) % 2 != 0));
              if ((n - L - 6) % 2 != 0)
                chk(a == hist_pix[L + 2*ja], "R3", a, hist_pix[L + 2*ja]);
              if (!intl) begin
                if (dtag == "") dtag = "R4";
                chk(a == hist_pix[L + 2*ja], dtag, a, hist_pix[L + 2*ja]);
                chk(b == hist_pix[L + 2*ja + 1], dtag, b, hist_pix[L + 2*ja + 1]);
              end else begin
                jb = (n - L - 7) / 2;
                if (dtag == "") dtag = "R5";
                chk(a == hist_pix[L + 2*ja], dtag, a, hist_pix[L + 2*ja]);
                chk(b == hist_pix[L + 2*jb + 1], dtag, b, hist_pix[L + 2*jb + 1]);
              end
            end
          end
        end
      end
      if (k == 0) begin
        cfg_dual = dual; cfg_interleave = intl; hs_active_low = alow;
      end
      if (k == flip_at) begin
        cfg_dual = ~dual; cfg_interleave = ~intl;
      end
      pwr_down = (pd_at >= 0 && k >= pd_at && k < pd_at + 3);
      drive(pgen(seed, k), k < hw);
    end
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0; pwr_down = 0; cfg_dual = 0; cfg_interleave = 0; hs_active_low = 0;
    drive(24'h0, 1'b0);
    repeat (4) step();
    rst_n = 1'b1;
    step();
    chk({porta_r, porta_g, porta_b} == 24'h0, "R12", {porta_r, porta_g, porta_b}, 24'h0);
    chk(porta_oe == 1'b1, "R12", 24'(porta_oe), 24'd1);
    chk(portb_oe == 1'b0, "R12", 24'(portb_oe), 24'd0);
    chk(hs_out == 1'b0, "R12", 24'(hs_out), 24'd0);
    chk(dclk == 1'b0, "R12", 24'(dclk), 24'd0);
    for (int i = 0; i < 10; i++) begin
      drive(24'h0, 1'b0);
      step();
    end
  endtask

  task automatic t_single();      run_line(0, 0, 0, 32, 6, 5,  -1, -1); endtask
  task automatic t_parallel();    run_line(1, 0, 0, 32, 6, 17, -1, -1); endtask
  task automatic t_interleave();  run_line(1, 1, 0, 32, 7, 41, -1, -1); endtask
  task automatic t_active_low();  run_line(1, 0, 1, 32, 5, 77, -1, -1); endtask
  task automatic t_mode_hold();   run_line(0, 0, 0, 32, 6, 90, 14, -1);
                                  run_line(1, 1, 0, 32, 6, 23, 12, -1); endtask
  task automatic t_powerdown();   run_line(1, 0, 0, 32, 6, 60, -1, 16);
                                  run_line(0, 0, 0, 32, 6, 33, -1, 12); endtask

  initial begin
    for (int i = 0; i < 4096; i++) begin hist_pix[i] = '0; hist_hs[i] = 1'b0; end
    hs_in = 0;
    t_reset_state();
    t_single();
    t_parallel();
    t_interleave();
    t_single();
    t_active_low();
    t_mode_hold();
    t_powerdown();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule